// File: doc/BRIEF.md
# Strobed Output Handshake Channel

This block is an output port with a buffer-full handshake. A host pulses an active-low write strobe with a data word. When the strobe returns high, the block latches the word onto the port lines and pulls an active-low "buffer full" flag low. The flag tells the peripheral that unread data is waiting.

The peripheral takes the word and answers with an active-low acknowledge pulse. The falling edge of acknowledge releases the full flag. The rising edge raises an interrupt request, if interrupts are enabled, so that the host supplies the next word. The interrupt clears as soon as the host begins its next write. With interrupts disabled, the request stays low and the host polls the flag instead.

Both strobes arrive from outside the clock domain. Each one passes through a synchronizer of configurable depth and then an edge detector before it is used.

Top module: `strobed_out_chan`

## Requirements
- R1: While `rst` is high and after it is released, `full_n` is 1, `irq` is 0 and `port_data` equals `RESET_DATA`.
- R2: A rising edge on `wr_n` (write complete) loads `wr_data` onto `port_data` and drives `full_n` to 0.
- R3: `port_data` changes only on a completed write. Changes on `wr_data`, a falling `wr_n` and acknowledge pulses leave it unchanged.
- R4: A falling edge on `ack_n` drives `full_n` to 1.
- R5: A rising edge on `ack_n` while `irq_en` is 1 sets `irq` to 1.
- R6: While `irq_en` is 0, `irq` stays 0 through acknowledge pulses, and `full_n` is still released by acknowledge.
- R7: A falling edge on `wr_n` (write start) clears `irq` before the write completes.
- R8: Dropping `irq_en` to 0 clears a pending `irq` on the next clock edge.
- R9: `wr_n` held low alone does not assert `full_n`; the flag falls only when the write completes.
- R10: An edge on `wr_n` or `ack_n` first shows on the outputs at the (`SYNC_STAGES`+1)-th rising clock edge that samples the new level, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| wr_data | input | DATA_W | Host data word, held stable until the write completes |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| irq_en | input | 1 | Interrupt enable; 0 selects polled operation |
| port_data | output | DATA_W | Latched output word driven to the peripheral |
| full_n | output | 1 | Buffer-full flag, active low |
| irq | output | 1 | Interrupt request to the host, active high |

## Verification
The bench builds the block with `DATA_W` = 12, `SYNC_STAGES` = 3 and a non-zero `RESET_DATA`. These values show the word width is not tied to a byte, and show the reset value at the port. The three-stage synchronizer spreads each strobe edge over several cycles. The latency checks can then tell a correct (`SYNC_STAGES`+1)-edge response from one that arrives a cycle early or late. The odd word width also catches truncation in the data latch.

// File: rtl/sochan_pkg.sv
`timescale 1ns/1ps
package sochan_pkg;
   // Edge events produced by a synchronized strobe
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ev_t;
endpackage

// File: rtl/sochan_sync_edge.sv
`timescale 1ns/1ps
module sochan_sync_edge #(
   parameter int  STAGES   = 2,
   parameter bit  IDLE_LVL = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  din,
   output sochan_pkg::edge_ev_t  ev
);
   logic sig;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign sig = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst) chain_q <= {STAGES{IDLE_LVL}};
            else     chain_q <= {chain_q[STAGES-2:0], din};
         end
         assign sig = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= IDLE_LVL;
      else     prev_q <= sig;
   end

   assign ev.rise = sig & ~prev_q;
   assign ev.fall = ~sig & prev_q;
endmodule

// File: rtl/sochan_hs_ctrl.sv
`timescale 1ns/1ps
module sochan_hs_ctrl #(
   parameter int              DATA_W     = 8,
   parameter logic [DATA_W-1:0] RESET_DATA = '0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  sochan_pkg::edge_ev_t  wr_ev,
   input  sochan_pkg::edge_ev_t  ack_ev,
   input  logic                  irq_en,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     data_q,
   output logic                  full_n,
   output logic                  irq
);
   // Data latch: loaded only when a write completes
   always_ff @(posedge clk) begin
      if (rst)             data_q <= RESET_DATA;
      else if (wr_ev.rise) data_q <= wr_data;
   end

   // Full flag: a completed write wins over a simultaneous release
   always_ff @(posedge clk) begin
      if (rst)              full_n <= 1'b1;
      else if (wr_ev.rise)  full_n <= 1'b0;
      else if (ack_ev.fall) full_n <= 1'b1;
   end

   // Interrupt: gated by enable, cleared by write start
   always_ff @(posedge clk) begin
      if (rst)              irq <= 1'b0;
      else if (!irq_en)     irq <= 1'b0;
      else if (wr_ev.fall)  irq <= 1'b0;
      else if (ack_ev.rise) irq <= 1'b1;
   end

   // R2
   full_set_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(full_n) |-> $past(wr_ev.rise));
   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_ev.rise |=> $stable(data_q));
   // R4
   full_rel_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(full_n) |-> $past(ack_ev.fall));
   // R5
   irq_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> $past(ack_ev.rise && irq_en));
   // R6
   irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !irq_en |=> !irq);
   // R7
   irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(irq) |-> $past(wr_ev.fall || !irq_en));
endmodule

// File: rtl/strobed_out_chan.sv
`timescale 1ns/1ps
module strobed_out_chan #(
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] RESET_DATA  = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ack_n,
   input  logic              irq_en,
   output logic [DATA_W-1:0] port_data,
   output logic              full_n,
   output logic              irq
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   sochan_pkg::edge_ev_t wr_ev;
   sochan_pkg::edge_ev_t ack_ev;

   sochan_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_wr_sync (
      .clk (clk),
      .rst (rst),
      .din (wr_n),
      .ev  (wr_ev)
   );

   sochan_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_ack_sync (
      .clk (clk),
      .rst (rst),
      .din (ack_n),
      .ev  (ack_ev)
   );

   sochan_hs_ctrl #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .wr_ev   (wr_ev),
      .ack_ev  (ack_ev),
      .irq_en  (irq_en),
      .wr_data (wr_data),
      .data_q  (port_data),
      .full_n  (full_n),
      .irq     (irq)
   );
endmodule

// File: tb/test_strobed_out_chan.sv
`timescale 1ns/1ps
module test_strobed_out_chan;
   localparam int          DW  = 12;
   localparam int          NS  = 3;
   localparam logic [DW-1:0] RST_VAL = 12'hA5C;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_n = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic          ack_n = 1'b1;
   logic          irq_en = 1'b0;
   logic [DW-1:0] port_data;
   logic          full_n;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   strobed_out_chan #(.DATA_W(DW), .SYNC_STAGES(NS), .RESET_DATA(RST_VAL)) i_strobed_out_chan (
      .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data), .ack_n(ack_n),
      .irq_en(irq_en), .port_data(port_data), .full_n(full_n), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic drive_at_neg(output bit dummy);
      @(negedge clk);
      dummy = 1'b0;
   endtask

   task automatic do_write(input logic [DW-1:0] d);
      bit x;
      drive_at_neg(x);
      wr_data = d;
      wr_n = 1'b0;
      cyc(NS + 3);
      drive_at_neg(x);
      wr_n = 1'b1;
      cyc(NS + 3);
   endtask

   task automatic do_ack();
      bit x;
      drive_at_neg(x);
      ack_n = 1'b0;
      cyc(NS + 3);
      drive_at_neg(x);
      ack_n = 1'b1;
      cyc(NS + 3);
   endtask

   task automatic t_reset();
      chk(full_n == 1'b1, "R1 full_n after reset", full_n, 1);
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
      chk(port_data == RST_VAL, "R1 port_data after reset", port_data, RST_VAL);
   endtask

   task automatic t_write_timing();
      bit x;
      drive_at_neg(x);
      wr_data = 12'h3C7;
      wr_n = 1'b0;
      cyc(NS + 3);
      chk(full_n == 1'b1, "R9 full_n with write held low", full_n, 1);
      chk(port_data == RST_VAL, "R3 data unchanged at write start", port_data, RST_VAL);
      drive_at_neg(x);
      wr_n = 1'b1;
      cyc(NS);
      chk(full_n == 1'b1, "R10 full_n not early", full_n, 1);
      cyc(1);
      chk(full_n == 1'b0, "R10 R2 full_n on time", full_n, 0);
      chk(port_data == 12'h3C7, "R2 port_data loaded", port_data, 12'h3C7);
      drive_at_neg(x);
      wr_data = 12'h0F0;
      cyc(NS + 3);
      chk(port_data == 12'h3C7, "R3 data holds after wr_data change", port_data, 12'h3C7);
   endtask

   task automatic t_ack_irq();
      bit x;
      irq_en = 1'b1;
      drive_at_neg(x);
      ack_n = 1'b0;
      cyc(NS);
      chk(full_n == 1'b0, "R10 release not early", full_n, 0);
      cyc(1);
      chk(full_n == 1'b1, "R4 full_n released", full_n, 1);
      chk(irq == 1'b0, "R5 irq waits for ack end", irq, 0);
      drive_at_neg(x);
      ack_n = 1'b1;
      cyc(NS);
      chk(irq == 1'b0, "R10 irq not early", irq, 0);
      cyc(1);
      chk(irq == 1'b1, "R5 irq set at ack end", irq, 1);
      chk(port_data == 12'h3C7, "R3 data holds across ack", port_data, 12'h3C7);
   endtask

   task automatic t_write_clears_irq();
      bit x;
      drive_at_neg(x);
      wr_data = 12'hFFF;
      wr_n = 1'b0;
      cyc(NS + 2);
      chk(irq == 1'b0, "R7 irq cleared at write start", irq, 0);
      chk(full_n == 1'b1, "R9 full_n high before completion", full_n, 1);
      drive_at_neg(x);
      wr_n = 1'b1;
      cyc(NS + 2);
      chk(full_n == 1'b0, "R2 full_n after write", full_n, 0);
      chk(port_data == 12'hFFF, "R2 all-ones word", port_data, 12'hFFF);
   endtask

   task automatic t_poll_mode();
      irq_en = 1'b0;
      do_ack();
      chk(full_n == 1'b1, "R6 full_n released in poll mode", full_n, 1);
      chk(irq == 1'b0, "R6 irq quiet in poll mode", irq, 0);
      do_write(12'h000);
      chk(port_data == 12'h000, "R2 all-zero word", port_data, 12'h000);
      chk(full_n == 1'b0, "R2 full_n after poll write", full_n, 0);
   endtask

   task automatic t_disable_clears();
      bit x;
      irq_en = 1'b1;
      do_ack();
      chk(irq == 1'b1, "R5 irq pending", irq, 1);
      drive_at_neg(x);
      irq_en = 1'b0;
      cyc(1);
      chk(irq == 1'b0, "R8 irq cleared by disable", irq, 0);
      chk(full_n == 1'b1, "R8 full_n unaffected by disable", full_n, 1);
   endtask

   initial begin
      cyc(4);
      t_reset();
      @(negedge clk);
      rst = 1'b0;
      cyc(NS + 3);
      t_reset();
      t_write_timing();
      t_ack_irq();
      t_write_clears_irq();
      t_poll_mode();
      t_disable_clears();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule